// File: doc/BRIEF.md
# Pipeline Forwarding and Early-Branch Hazard Unit

This block resolves data hazards in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) whose branches are resolved in decode. Each cycle it looks at the source register numbers in decode and execute. It also looks at the destination numbers, write enables, load flags and result values of the instructions in execute, memory and writeback. From these it drives forwarding selects for the two execute operands, for the store-data path of a store in the memory stage, and for the two inputs of the decode-stage branch comparator.

The comparator muxes and the equality compare sit inside the block, so it also produces the branch outcome and a one-cycle fetch flush. A load that is in the memory stage feeds its read data straight into the comparator. A branch that depends on the load just ahead of it by one slot therefore resolves without a stall. Only a decode instruction that needs the result of a load still in execute causes a single-cycle stall. The register file, ALU, memories and instruction decode are outside the block and appear only as ports.

Top module: `hzd_fwd_unit`

## Requirements
- R1: `exSelA` / `exSelB` pick the source of the execute operands named by `exRs` / `exRt`: 2 = memory-stage result, when the memory instruction writes a matching non-zero register; otherwise 1 = writeback result, when writeback writes it; otherwise 0 = the pipeline's own operand. A memory-stage match wins over a writeback match.
- R2: Register 0 is never forwarded. A write whose destination is 0 matches nothing, every select for a source of 0 is 0, and a branch operand naming register 0 compares as zero whatever the register-file value.
- R3: `brSelA` / `brSelB` pick the comparator inputs for `decRs` / `decRt`: 3 = execute ALU result, 2 = memory stage, 1 = writeback, 0 = register file. The youngest writer wins (execute, then memory, then writeback).
- R4: When the memory-stage instruction is a load, select 2 feeds `memLoadData` to the comparator; otherwise it feeds `memAluResult`. A branch that depends on a load in the memory stage does not stall.
- R5: `stall` is 1 exactly when a source that decode uses (`decUsesRs` / `decUsesRt`) equals the non-zero destination of a load in execute that writes. This applies to branches and other instructions alike.
- R6: While `stall` is 1, `branchTaken` and `flushFetch` are 0.
- R7: `memStoreSel` is 1 exactly when the memory-stage instruction is a store and writeback writes the non-zero register `memStoreReg`. The store then takes the writeback value instead of its own data.
- R8: With `decIsBranch`=1 and no stall, `branchTaken` is 1 on equal operands when `decBranchNe`=0 and on unequal operands when `decBranchNe`=1. `flushFetch` always equals `branchTaken`, and a non-branch is never taken.
- R9: The sequence address increment, load based on that register, second load based on it, branch on the first load's result, and store of the second load's result runs with `stall`=0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decRs | input | RW | first source register of the decode instruction |
| decRt | input | RW | second source register of the decode instruction |
| decUsesRs | input | 1 | decode instruction reads `decRs` |
| decUsesRt | input | 1 | decode instruction reads `decRt` |
| decIsBranch | input | 1 | decode instruction is a conditional branch |
| decBranchNe | input | 1 | branch is taken on inequality (0: on equality) |
| rfRsData | input | DW | register-file value for `decRs` |
| rfRtData | input | DW | register-file value for `decRt` |
| exRs | input | RW | first source register of the execute instruction |
| exRt | input | RW | second source register of the execute instruction |
| exDest | input | RW | destination of the execute instruction |
| exWrite | input | 1 | execute instruction writes a register |
| exIsLoad | input | 1 | execute instruction is a load |
| exAluResult | input | DW | ALU output of the execute stage |
| memDest | input | RW | destination of the memory-stage instruction |
| memWrite | input | 1 | memory-stage instruction writes a register |
| memIsLoad | input | 1 | memory-stage instruction is a load |
| memAluResult | input | DW | ALU result carried in the memory stage |
| memLoadData | input | DW | data read by a load in the memory stage |
| memIsStore | input | 1 | memory-stage instruction is a store |
| memStoreReg | input | RW | register holding the store's data |
| wbDest | input | RW | destination of the writeback instruction |
| wbWrite | input | 1 | writeback instruction writes a register |
| wbResult | input | DW | value being written back |
| exSelA | output | 2 | forwarding select for execute operand A |
| exSelB | output | 2 | forwarding select for execute operand B |
| memStoreSel | output | 1 | store data taken from writeback |
| brSelA | output | 2 | comparator select for operand A |
| brSelB | output | 2 | comparator select for operand B |
| stall | output | 1 | hold fetch and decode, bubble into execute |
| branchTaken | output | 1 | branch in decode is taken |
| flushFetch | output | 1 | kill the instruction in fetch |

## Verification
The hardest case to reach from the ports is the pair of hazards the block treats differently. A branch that depends on a load must stall when the load sits in execute, yet resolve at once on the load's read data one cycle later, with the same register also pending in writeback so that priority matters. Random vectors draw register numbers from a four-entry range, so destinations, sources and register 0 collide often, and draw data from a tiny range, so equal operands are common. Directed cycles replay the increment, load, load, branch, store sequence stage by stage and pin each select, the stall and the branch outcome.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    EX_PIPE = 2'd0,
    EX_WB   = 2'd1,
    EX_MEM  = 2'd2
  } exSel_e;

  typedef enum logic [1:0] {
    BR_RF  = 2'd0,
    BR_WB  = 2'd1,
    BR_MEM = 2'd2,
    BR_EX  = 2'd3
  } brSel_e;

  typedef struct packed {
    brSel_e selA;
    brSel_e selB;
    logic   zeroA;
    logic   zeroB;
    logic   enable;
    logic   invert;
  } brStrobe_t;
endpackage

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] decRs,
  input  logic [RW-1:0] decRt,
  input  logic          decUsesRs,
  input  logic          decUsesRt,
  input  logic          decIsBranch,
  input  logic          decBranchNe,
  input  logic [RW-1:0] exRs,
  input  logic [RW-1:0] exRt,
  input  logic [RW-1:0] exDest,
  input  logic          exWrite,
  input  logic          exIsLoad,
  input  logic [RW-1:0] memDest,
  input  logic          memWrite,
  input  logic          memIsStore,
  input  logic [RW-1:0] memStoreReg,
  input  logic [RW-1:0] wbDest,
  input  logic          wbWrite,
  output exSel_e        exSelA,
  output exSel_e        exSelB,
  output logic          memStoreSel,
  output logic          stall,
  output brStrobe_t     strobe
);
  localparam int NOPND = 2;

  function automatic logic hits(input logic wr, input logic [RW-1:0] dst,
                                input logic [RW-1:0] src);
    return wr && (dst != '0) && (dst == src);
  endfunction

  logic [RW-1:0] decSrc [NOPND];
  logic [RW-1:0] exSrc  [NOPND];
  logic [NOPND-1:0] decUses;
  logic [NOPND-1:0] loadUse;
  exSel_e exSel [NOPND];
  brSel_e brSel [NOPND];

  assign decSrc[0] = decRs;
  assign decSrc[1] = decRt;
  assign exSrc[0]  = exRs;
  assign exSrc[1]  = exRt;
  assign decUses   = {decUsesRt, decUsesRs};

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    assign exSel[i] = hits(memWrite, memDest, exSrc[i]) ? EX_MEM :
                      hits(wbWrite, wbDest, exSrc[i])   ? EX_WB  : EX_PIPE;
    assign brSel[i] = hits(exWrite, exDest, decSrc[i])  ? BR_EX  :
                      hits(memWrite, memDest, decSrc[i]) ? BR_MEM :
                      hits(wbWrite, wbDest, decSrc[i])   ? BR_WB  : BR_RF;
    assign loadUse[i] = decUses[i] && exIsLoad && hits(exWrite, exDest, decSrc[i]);
  end

  assign stall       = |loadUse;
  assign exSelA      = exSel[0];
  assign exSelB      = exSel[1];
  assign memStoreSel = memIsStore && hits(wbWrite, wbDest, memStoreReg);

  always_comb begin
    strobe.selA   = brSel[0];
    strobe.selB   = brSel[1];
    strobe.zeroA  = (decRs == '0);
    strobe.zeroB  = (decRt == '0);
    strobe.enable = decIsBranch && !stall;
    strobe.invert = decBranchNe;
  end
endmodule

// File: rtl/hzd_path.sv
module hzd_path
  import hzd_pkg::*;
#(
  parameter int DW = 32
) (
  input  brStrobe_t     strobe,
  input  logic [DW-1:0] rfRsData,
  input  logic [DW-1:0] rfRtData,
  input  logic [DW-1:0] exAluResult,
  input  logic          memIsLoad,
  input  logic [DW-1:0] memAluResult,
  input  logic [DW-1:0] memLoadData,
  input  logic [DW-1:0] wbResult,
  output logic          branchTaken,
  output logic          flushFetch
);
  logic [DW-1:0] memValue;
  logic [DW-1:0] opA;
  logic [DW-1:0] opB;
  logic          same;

  assign memValue = memIsLoad ? memLoadData : memAluResult;

  function automatic logic [DW-1:0] pick(input brSel_e sel, input logic zero,
                                         input logic [DW-1:0] rf);
    case (sel)
      BR_EX:   return exAluResult;
      BR_MEM:  return memValue;
      BR_WB:   return wbResult;
      default: return zero ? '0 : rf;
    endcase
  endfunction

  assign opA         = pick(strobe.selA, strobe.zeroA, rfRsData);
  assign opB         = pick(strobe.selB, strobe.zeroB, rfRtData);
  assign same        = (opA == opB);
  assign branchTaken = strobe.enable && (same ^ strobe.invert);
  assign flushFetch  = branchTaken;
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic [RW-1:0] decRs,
  input  logic [RW-1:0] decRt,
  input  logic          decUsesRs,
  input  logic          decUsesRt,
  input  logic          decIsBranch,
  input  logic          decBranchNe,
  input  logic [DW-1:0] rfRsData,
  input  logic [DW-1:0] rfRtData,
  input  logic [RW-1:0] exRs,
  input  logic [RW-1:0] exRt,
  input  logic [RW-1:0] exDest,
  input  logic          exWrite,
  input  logic          exIsLoad,
  input  logic [DW-1:0] exAluResult,
  input  logic [RW-1:0] memDest,
  input  logic          memWrite,
  input  logic          memIsLoad,
  input  logic [DW-1:0] memAluResult,
  input  logic [DW-1:0] memLoadData,
  input  logic          memIsStore,
  input  logic [RW-1:0] memStoreReg,
  input  logic [RW-1:0] wbDest,
  input  logic          wbWrite,
  input  logic [DW-1:0] wbResult,
  output logic [1:0]    exSelA,
  output logic [1:0]    exSelB,
  output logic          memStoreSel,
  output logic [1:0]    brSelA,
  output logic [1:0]    brSelB,
  output logic          stall,
  output logic          branchTaken,
  output logic          flushFetch
);
  brStrobe_t strobe;
  exSel_e    exSelAe;
  exSel_e    exSelBe;

  hzd_ctrl #(.RW(RW)) u_ctrl (
    .decRs(decRs), .decRt(decRt), .decUsesRs(decUsesRs), .decUsesRt(decUsesRt),
    .decIsBranch(decIsBranch), .decBranchNe(decBranchNe),
    .exRs(exRs), .exRt(exRt), .exDest(exDest), .exWrite(exWrite), .exIsLoad(exIsLoad),
    .memDest(memDest), .memWrite(memWrite), .memIsStore(memIsStore),
    .memStoreReg(memStoreReg), .wbDest(wbDest), .wbWrite(wbWrite),
    .exSelA(exSelAe), .exSelB(exSelBe), .memStoreSel(memStoreSel),
    .stall(stall), .strobe(strobe)
  );

  hzd_path #(.DW(DW)) u_path (
    .strobe(strobe), .rfRsData(rfRsData), .rfRtData(rfRtData),
    .exAluResult(exAluResult), .memIsLoad(memIsLoad), .memAluResult(memAluResult),
    .memLoadData(memLoadData), .wbResult(wbResult),
    .branchTaken(branchTaken), .flushFetch(flushFetch)
  );

  assign exSelA = exSelAe;
  assign exSelB = exSelBe;
  assign brSelA = strobe.selA;
  assign brSelB = strobe.selB;
endmodule

// File: rtl/hzd_fwd_checker.sv
module hzd_fwd_checker #(
  parameter int RW = 5
) (
  input logic [RW-1:0] decRs,
  input logic [RW-1:0] exRs,
  input logic [RW-1:0] exDest,
  input logic          exWrite,
  input logic          exIsLoad,
  input logic          decIsBranch,
  input logic          memIsStore,
  input logic          wbWrite,
  input logic [1:0]    exSelA,
  input logic [1:0]    brSelA,
  input logic          memStoreSel,
  input logic          stall,
  input logic          branchTaken,
  input logic          flushFetch
);
  always_comb begin
    if (stall) begin
      AST_STALL_NEEDS_EX_LOAD: assert (exIsLoad && exWrite && exDest != '0) else $error("stall without load in execute"); // R5
      AST_NO_TAKEN_WHILE_STALL: assert (!branchTaken) else $error("branch resolved during stall"); // R6
    end
    AST_FLUSH_FOLLOWS_TAKEN: assert (flushFetch == branchTaken) else $error("flush differs from outcome"); // R8
    if (branchTaken) begin
      AST_TAKEN_NEEDS_BRANCH: assert (decIsBranch) else $error("non-branch taken"); // R8
    end
    if (decRs == '0) begin
      AST_ZERO_NOT_FWD_BR: assert (brSelA == 2'd0) else $error("register 0 forwarded to comparator"); // R2
    end
    if (exRs == '0) begin
      AST_ZERO_NOT_FWD_EX: assert (exSelA == 2'd0) else $error("register 0 forwarded to execute"); // R2
    end
    if (memStoreSel) begin
      AST_STORE_SEL_SOURCE: assert (memIsStore && wbWrite) else $error("store select without store and writer"); // R7
    end
  end
endmodule

bind hzd_fwd_unit hzd_fwd_checker #(.RW(RW)) u_chk (
  .decRs(decRs), .exRs(exRs), .exDest(exDest), .exWrite(exWrite), .exIsLoad(exIsLoad),
  .decIsBranch(decIsBranch), .memIsStore(memIsStore), .wbWrite(wbWrite),
  .exSelA(exSelA), .brSelA(brSelA), .memStoreSel(memStoreSel), .stall(stall),
  .branchTaken(branchTaken), .flushFetch(flushFetch)
);

// File: tb/sim_hzd_fwd_unit.sv
`timescale 1ns/1ps
module sim_hzd_fwd_unit;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0] decRs = '0, decRt = '0, exRs = '0, exRt = '0, exDest = '0;
  logic [RW-1:0] memDest = '0, memStoreReg = '0, wbDest = '0;
  logic decUsesRs = 1'b0, decUsesRt = 1'b0, decIsBranch = 1'b0, decBranchNe = 1'b0;
  logic exWrite = 1'b0, exIsLoad = 1'b0, memWrite = 1'b0, memIsLoad = 1'b0;
  logic memIsStore = 1'b0, wbWrite = 1'b0;
  logic [DW-1:0] rfRsData = '0, rfRtData = '0, exAluResult = '0;
  logic [DW-1:0] memAluResult = '0, memLoadData = '0, wbResult = '0;
  logic [1:0] exSelA, exSelB, brSelA, brSelB;
  logic memStoreSel, stall, branchTaken, flushFetch;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  hzd_fwd_unit #(.RW(RW), .DW(DW)) u0 (.*);

  localparam logic [RW-1:0] T0 = 5'd8, S0 = 5'd16, V0 = 5'd2;

  function automatic bit hit(input logic wr, input logic [RW-1:0] d, input logic [RW-1:0] s);
    return wr && d != '0 && d == s;
  endfunction
  function automatic int expEx(input logic [RW-1:0] s);
    if (hit(memWrite, memDest, s)) return 2;
    if (hit(wbWrite, wbDest, s)) return 1;
    return 0;
  endfunction
  function automatic int expBr(input logic [RW-1:0] s);
    if (hit(exWrite, exDest, s)) return 3;
    if (hit(memWrite, memDest, s)) return 2;
    if (hit(wbWrite, wbDest, s)) return 1;
    return 0;
  endfunction
  function automatic logic [DW-1:0] expVal(input logic [RW-1:0] s, input logic [DW-1:0] rf);
    case (expBr(s))
      3: return exAluResult;
      2: return memIsLoad ? memLoadData : memAluResult;
      1: return wbResult;
      default: return (s == '0) ? '0 : rf;
    endcase
  endfunction
  function automatic bit expStall();
    return exIsLoad && hit(exWrite, exDest, exDest) &&
           ((decUsesRs && decRs == exDest) || (decUsesRt && decRt == exDest));
  endfunction
  function automatic bit expTaken();
    return decIsBranch && !expStall() &&
           ((expVal(decRs, rfRsData) == expVal(decRt, rfRtData)) != decBranchNe);
  endfunction
  function automatic bit expStore();
    return memIsStore && hit(wbWrite, wbDest, memStoreReg);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkModel(input string tag);
    chk("R1", {tag, " exSelA"}, int'(exSelA), expEx(exRs));
    chk("R1", {tag, " exSelB"}, int'(exSelB), expEx(exRt));
    chk("R3", {tag, " brSelA"}, int'(brSelA), expBr(decRs));
    chk("R3", {tag, " brSelB"}, int'(brSelB), expBr(decRt));
    chk("R5", {tag, " stall"}, int'(stall), int'(expStall()));
    chk("R8", {tag, " taken"}, int'(branchTaken), int'(expTaken()));
    chk("R8", {tag, " flush"}, int'(flushFetch), int'(expTaken()));
    chk("R7", {tag, " storeSel"}, int'(memStoreSel), int'(expStore()));
  endtask

  task automatic clearAll();
    decRs = '0; decRt = '0; decUsesRs = 0; decUsesRt = 0; decIsBranch = 0; decBranchNe = 0;
    exRs = '0; exRt = '0; exDest = '0; exWrite = 0; exIsLoad = 0;
    memDest = '0; memWrite = 0; memIsLoad = 0; memIsStore = 0; memStoreReg = '0;
    wbDest = '0; wbWrite = 0;
    rfRsData = '0; rfRtData = '0; exAluResult = '0; memAluResult = '0; memLoadData = '0; wbResult = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clearAll();
    step();
    // reset state: all idle
    chk("R1", "idle exSelA", int'(exSelA), 0);
    chk("R3", "idle brSelA", int'(brSelA), 0);
    chk("R5", "idle stall", int'(stall), 0);
    chk("R8", "idle taken", int'(branchTaken), 0);

    // R9 sequence, cycle 3: decode load s0 off t0, execute increment of t0
    clearAll();
    decRs = T0; decRt = S0; decUsesRs = 1;
    exRs = T0; exDest = T0; exWrite = 1; exAluResult = 32'd104;
    step();
    chk("R3", "seq c3 brSelA", int'(brSelA), 3);
    chk("R9", "seq c3 stall", int'(stall), 0);
    // cycle 4: decode load v0, execute load s0, memory increment
    clearAll();
    decRs = T0; decRt = V0; decUsesRs = 1;
    exRs = T0; exDest = S0; exWrite = 1; exIsLoad = 1;
    memDest = T0; memWrite = 1; memAluResult = 32'd104;
    step();
    chk("R1", "seq c4 exSelA", int'(exSelA), 2);
    chk("R3", "seq c4 brSelA", int'(brSelA), 2);
    chk("R9", "seq c4 stall", int'(stall), 0);
    // cycle 5: decode branch on s0 vs zero, memory load s0 reads 0
    clearAll();
    decRs = S0; decRt = '0; decUsesRs = 1; decUsesRt = 1; decIsBranch = 1; decBranchNe = 1;
    rfRsData = 32'd77; rfRtData = 32'd99;
    exRs = T0; exDest = V0; exWrite = 1; exIsLoad = 1;
    memDest = S0; memWrite = 1; memIsLoad = 1; memAluResult = 32'd5; memLoadData = 32'd0;
    wbDest = T0; wbWrite = 1; wbResult = 32'd104;
    step();
    chk("R1", "seq c5 exSelA", int'(exSelA), 1);
    chk("R4", "seq c5 brSelA", int'(brSelA), 2);
    chk("R2", "seq c5 brSelB", int'(brSelB), 0);
    chk("R9", "seq c5 stall", int'(stall), 0);
    chk("R4", "seq c5 load data drives compare", int'(branchTaken), 0);
    memLoadData = 32'd7;
    #1;
    chk("R4", "seq c5 nonzero load taken", int'(branchTaken), 1);
    chk("R8", "seq c5 flush", int'(flushFetch), 1);
    // cycle 6: decode store (t0, v0), execute branch, memory load v0
    clearAll();
    decRs = T0; decRt = V0; decUsesRs = 1; decUsesRt = 1;
    exRs = S0; exRt = '0;
    memDest = V0; memWrite = 1; memIsLoad = 1; memLoadData = 32'd55;
    wbDest = S0; wbWrite = 1;
    step();
    chk("R3", "seq c6 brSelB", int'(brSelB), 2);
    chk("R1", "seq c6 exSelA", int'(exSelA), 1);
    chk("R2", "seq c6 exSelB", int'(exSelB), 0);
    chk("R9", "seq c6 stall", int'(stall), 0);
    chk("R8", "seq c6 non-branch", int'(branchTaken), 0);
    // cycle 7: execute store, writeback load v0
    clearAll();
    exRs = T0; exRt = V0; wbDest = V0; wbWrite = 1; wbResult = 32'd55;
    step();
    chk("R1", "seq c7 exSelB", int'(exSelB), 1);
    chk("R9", "seq c7 stall", int'(stall), 0);

    // R5/R6: branch on load still in execute, operands equal -> stall, not taken
    clearAll();
    decRs = 5'd3; decRt = 5'd3; decUsesRs = 1; decUsesRt = 1; decIsBranch = 1;
    exDest = 5'd3; exWrite = 1; exIsLoad = 1;
    step();
    chk("R5", "branch after ex load stall", int'(stall), 1);
    chk("R6", "no taken during stall", int'(branchTaken), 0);
    chk("R6", "no flush during stall", int'(flushFetch), 0);
    // R5: unused source does not stall
    decUsesRt = 0; decRs = 5'd4; decIsBranch = 0;
    #1;
    chk("R5", "unused source no stall", int'(stall), 0);
    // R3: ALU in execute feeds comparator, priority over mem and wb
    clearAll();
    decRs = 5'd6; decRt = 5'd7; decUsesRs = 1; decUsesRt = 1; decIsBranch = 1;
    exDest = 5'd6; exWrite = 1; exAluResult = 32'd11;
    memDest = 5'd6; memWrite = 1; memAluResult = 32'd12;
    wbDest = 5'd6; wbWrite = 1; wbResult = 32'd13; rfRtData = 32'd11;
    step();
    chk("R3", "youngest priority", int'(brSelA), 3);
    chk("R3", "ex ALU equal taken", int'(branchTaken), 1);
    // R2: writes to register 0 are ignored; operand 0 reads zero
    clearAll();
    decRs = '0; decRt = 5'd9; decUsesRs = 1; decUsesRt = 1; decIsBranch = 1;
    rfRsData = 32'd5; rfRtData = 32'd0;
    exRs = '0; exDest = '0; exWrite = 1; exIsLoad = 1; memDest = '0; memWrite = 1; wbDest = '0; wbWrite = 1;
    step();
    chk("R2", "reg0 brSelA", int'(brSelA), 0);
    chk("R2", "reg0 exSelA", int'(exSelA), 0);
    chk("R2", "reg0 no stall", int'(stall), 0);
    chk("R2", "reg0 reads zero", int'(branchTaken), 1);
    // R7: store right after load takes writeback value
    clearAll();
    memIsStore = 1; memStoreReg = 5'd5; wbDest = 5'd5; wbWrite = 1;
    step();
    chk("R7", "store fwd", int'(memStoreSel), 1);
    wbDest = 5'd6;
    #1;
    chk("R7", "store no match", int'(memStoreSel), 0);

    // random mix, small register and value ranges
    for (int i = 0; i < 3000; i++) begin
      decRs = RW'($urandom % 4); decRt = RW'($urandom % 4);
      decUsesRs = 1'($urandom); decUsesRt = 1'($urandom);
      decIsBranch = 1'($urandom); decBranchNe = 1'($urandom);
      exRs = RW'($urandom % 4); exRt = RW'($urandom % 4); exDest = RW'($urandom % 4);
      exWrite = 1'($urandom); exIsLoad = 1'($urandom);
      memDest = RW'($urandom % 4); memWrite = 1'($urandom); memIsLoad = 1'($urandom);
      memIsStore = 1'($urandom); memStoreReg = RW'($urandom % 4);
      wbDest = RW'($urandom % 4); wbWrite = 1'($urandom);
      rfRsData = DW'($urandom % 3); rfRtData = DW'($urandom % 3);
      exAluResult = DW'($urandom % 3); memAluResult = DW'($urandom % 3);
      memLoadData = DW'($urandom % 3); wbResult = DW'($urandom % 3);
      step();
      checkModel("rand");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule